// File: doc/BRIEF.md
# DMA Channel Control and Interrupt Status Registers

This block is the global register bank of a multi-channel DMA engine. It stores a transfer mode and a direction bit for each channel and an interrupt enable for each channel. It gathers completion and error pulses from the channel engines into sticky flags, and it drives a single interrupt line toward the host. Software starts a channel by writing a non-zero mode into that channel's field. The block answers with a one-cycle start pulse on that channel's side-band output.

Channels 0 to 7 live in one register group and channels 8 to 11 in a second group. Within the second group, channels are renumbered from zero, except in the enable word. Each status word mixes three kinds of field: read-only phase fields that come straight from the channel engines, interrupt flags, and error flags. Software clears a flag by writing a one to its bit. Reads are combinational on a 32-bit word port addressed by byte offset. The channel datapaths and the descriptor registers are outside this block.

Top module: `dmacs_regs`

## Requirements
- R1: After reset every mode, direction, enable and flag is zero, `irq` is low, and every offset from 0x00 to 0x18 reads zero while the phase inputs are zero.
- R2: Channel n below 8 is held in the nibble at bits 4n+3..4n of offset 0x00, and channel n of 8 or more is held in nibble n-8 of offset 0x0C. In each nibble, bits 1:0 are the mode, bit 2 is the direction and bit 3 reads zero. `ch_mode` and `ch_dir` show the stored values from the cycle after the write.
- R3: The mode codes are 0 off, 1 descriptor chain and 2 single block; code 3 is stored as written. In the cycle after a write that puts a non-zero mode in a channel's field, that channel's `ch_start` is high for exactly one cycle. A zero mode gives no pulse.
- R4: At offset 0x08, channel n below 8 is enabled by bit n and channel n of 8 or more by bit n+8. All other bits read zero.
- R5: A `ch_done` pulse sets the interrupt flag of that channel. For channels below 8 the flag is bit n of offset 0x10; for channels of 8 or more it is bit n-8 of offset 0x18.
- R6: A `ch_err` pulse sets both the interrupt flag of that channel and its error flag, which sits 8 bits above the interrupt flag in the same word.
- R7: A write to 0x10 or 0x18 clears each flag whose bit is written as one and leaves the others alone. When a set pulse and a clearing write hit the same flag in the same cycle, the flag stays set.
- R8: Each channel's 2-bit phase input reads at bit 16+2k of its status word, where k is the in-group index. Writes to these bits have no effect.
- R9: `irq` is high exactly while some channel has both its interrupt flag and its enable set.
- R10: Offsets 0x04 and 0x14 read zero. Writes to them change no register and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | ADDR_W | Byte offset of the accessed word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| ch_done | input | NUM_CH | Per-channel completion pulse |
| ch_err | input | NUM_CH | Per-channel error pulse |
| ch_phase | input | 2*NUM_CH | Per-channel 2-bit engine phase |
| ch_mode | output | 2*NUM_CH | Per-channel stored mode |
| ch_dir | output | NUM_CH | Per-channel stored direction |
| ch_start | output | NUM_CH | Per-channel one-cycle start pulse |
| irq | output | 1 | Shared interrupt request |

## Verification
The assertions assume the following about the inputs: `ch_done` and `ch_err` are synchronous one-cycle events, and writes use word-aligned offsets. Under those conditions, set-wins and clear-on-one can each be checked one cycle later. The random stimulus writes only the seven defined offsets, with random data. It fires sparse done and error pulses on random channels and changes the phase inputs at every step. A few directed steps force the same-cycle set-and-clear collision and fill the second register group with all ones.

// File: rtl/dmacs_pkg.sv
`timescale 1ns/1ps
package dmacs_pkg;
   localparam int unsigned REG_W      = 32;
   localparam int unsigned GRP_CH     = 8;
   localparam int unsigned MAX_CH     = 12;
   localparam int unsigned OFS_CTL0   = 'h00;
   localparam int unsigned OFS_CTL1   = 'h04;
   localparam int unsigned OFS_CTL2   = 'h08;
   localparam int unsigned OFS_CTL3   = 'h0C;
   localparam int unsigned OFS_STS0   = 'h10;
   localparam int unsigned OFS_STS1   = 'h14;
   localparam int unsigned OFS_STS2   = 'h18;
   localparam int unsigned ERR_SHIFT  = 8;
   localparam int unsigned PHASE_BASE = 16;

   typedef enum logic [1:0] {
      MODE_OFF    = 2'd0,
      MODE_CHAIN  = 2'd1,
      MODE_SINGLE = 2'd2,
      MODE_RSVD   = 2'd3
   } xfer_mode_e;
endpackage

// File: rtl/dmacs_chan_cfg.sv
`timescale 1ns/1ps
module dmacs_chan_cfg
   import dmacs_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_sel,
   input  logic [3:0] wr_nib,
   output logic [1:0] mode_o,
   output logic       dir_o,
   output logic       start_o
);
   logic [1:0] mode_q;
   logic       dir_q;
   logic       start_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q  <= MODE_OFF;
         dir_q   <= 1'b0;
         start_q <= 1'b0;
      end else begin
         start_q <= 1'b0;
         if (wr_sel) begin
            mode_q  <= wr_nib[1:0];
            dir_q   <= wr_nib[2];
            start_q <= (wr_nib[1:0] != MODE_OFF);
         end
      end
   end

   assign mode_o  = mode_q;
   assign dir_o   = dir_q;
   assign start_o = start_q;

   logic unused_nib;
   assign unused_nib = wr_nib[3];

   // R2: fields only move on a write to their own register
   p_cfg_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_sel |=> ($stable(mode_q) && $stable(dir_q)));
   // R3: a start pulse always follows a write to this field
   p_start_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
      start_q |-> $past(wr_sel));
   // R3: the pulse lasts one cycle unless the field is written again
   p_start_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (start_q && !wr_sel) |=> !start_q);
endmodule

// File: rtl/dmacs_chan_flags.sv
`timescale 1ns/1ps
module dmacs_chan_flags (
   input  logic clk,
   input  logic rst_n,
   input  logic done_i,
   input  logic err_i,
   input  logic clr_wr,
   input  logic clr_int,
   input  logic clr_err,
   output logic int_o,
   output logic err_o
);
   logic int_q;
   logic err_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         int_q <= 1'b0;
         err_q <= 1'b0;
      end else begin
         if (done_i || err_i)        int_q <= 1'b1;
         else if (clr_wr && clr_int) int_q <= 1'b0;
         if (err_i)                  err_q <= 1'b1;
         else if (clr_wr && clr_err) err_q <= 1'b0;
      end
   end

   assign int_o = int_q;
   assign err_o = err_q;

   // R6: an error event raises both flags
   p_err_both_r6: assert property (@(posedge clk) disable iff (!rst_n)
      err_i |=> (int_q && err_q));
   // R7: a set event beats a simultaneous clear
   p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (done_i && clr_wr && clr_int) |=> int_q);
   // R7: a one written without a competing event clears the flag
   p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_wr && clr_int && !done_i && !err_i) |=> !int_q);
endmodule

// File: rtl/dmacs_regs.sv
`timescale 1ns/1ps
module dmacs_regs
   import dmacs_pkg::*;
#(
   parameter int unsigned NUM_CH = 12,
   parameter int unsigned ADDR_W = 5
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  reg_wr,
   input  logic [ADDR_W-1:0]     reg_addr,
   input  logic [31:0]           reg_wdata,
   output logic [31:0]           reg_rdata,
   input  logic [NUM_CH-1:0]     ch_done,
   input  logic [NUM_CH-1:0]     ch_err,
   input  logic [2*NUM_CH-1:0]   ch_phase,
   output logic [2*NUM_CH-1:0]   ch_mode,
   output logic [NUM_CH-1:0]     ch_dir,
   output logic [NUM_CH-1:0]     ch_start,
   output logic                  irq
);
   localparam int unsigned NIB_W = 4;

   if (NUM_CH < 1 || NUM_CH > MAX_CH) begin : g_bad_nch
      $error("dmacs_regs: NUM_CH out of range 1..12");
   end
   if (ADDR_W < 5) begin : g_bad_aw
      $error("dmacs_regs: ADDR_W must reach offset 0x18");
   end

   logic wr_ctl0, wr_ctl2, wr_ctl3, wr_sts0, wr_sts2;
   assign wr_ctl0 = reg_wr && (reg_addr == ADDR_W'(OFS_CTL0));
   assign wr_ctl2 = reg_wr && (reg_addr == ADDR_W'(OFS_CTL2));
   assign wr_ctl3 = reg_wr && (reg_addr == ADDR_W'(OFS_CTL3));
   assign wr_sts0 = reg_wr && (reg_addr == ADDR_W'(OFS_STS0));
   assign wr_sts2 = reg_wr && (reg_addr == ADDR_W'(OFS_STS2));

   logic [NUM_CH-1:0] int_v;
   logic [NUM_CH-1:0] err_v;
   logic [NUM_CH-1:0] en_q;

   for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
      localparam int unsigned K = n % GRP_CH;
      logic cfg_sel;
      logic clr_sel;
      if (n < GRP_CH) begin : g_lo
         assign cfg_sel = wr_ctl0;
         assign clr_sel = wr_sts0;
      end else begin : g_hi
         assign cfg_sel = wr_ctl3;
         assign clr_sel = wr_sts2;
      end

      dmacs_chan_cfg u_cfg (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_sel  (cfg_sel),
         .wr_nib  (reg_wdata[NIB_W*K +: NIB_W]),
         .mode_o  (ch_mode[2*n +: 2]),
         .dir_o   (ch_dir[n]),
         .start_o (ch_start[n])
      );

      dmacs_chan_flags u_flg (
         .clk     (clk),
         .rst_n   (rst_n),
         .done_i  (ch_done[n]),
         .err_i   (ch_err[n]),
         .clr_wr  (clr_sel),
         .clr_int (reg_wdata[K]),
         .clr_err (reg_wdata[K + ERR_SHIFT]),
         .int_o   (int_v[n]),
         .err_o   (err_v[n])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q <= '0;
      end else if (wr_ctl2) begin
         for (int n = 0; n < NUM_CH; n++)
            en_q[n] <= reg_wdata[(n < GRP_CH) ? n : n + GRP_CH];
      end
   end

   logic [31:0] ctl_lo, ctl_hi, en_w, sts_lo, sts_hi;
   always_comb begin
      ctl_lo = '0;
      ctl_hi = '0;
      en_w   = '0;
      sts_lo = '0;
      sts_hi = '0;
      for (int n = 0; n < NUM_CH; n++) begin
         if (n < GRP_CH) begin
            ctl_lo[NIB_W*(n%GRP_CH) +: NIB_W] = {1'b0, ch_dir[n], ch_mode[2*n +: 2]};
            en_w[n]                             = en_q[n];
            sts_lo[n%GRP_CH]                    = int_v[n];
            sts_lo[(n%GRP_CH) + ERR_SHIFT]      = err_v[n];
            sts_lo[PHASE_BASE + 2*(n%GRP_CH) +: 2] = ch_phase[2*n +: 2];
         end else begin
            ctl_hi[NIB_W*(n%GRP_CH) +: NIB_W] = {1'b0, ch_dir[n], ch_mode[2*n +: 2]};
            en_w[n + GRP_CH]                    = en_q[n];
            sts_hi[n%GRP_CH]                    = int_v[n];
            sts_hi[(n%GRP_CH) + ERR_SHIFT]      = err_v[n];
            sts_hi[PHASE_BASE + 2*(n%GRP_CH) +: 2] = ch_phase[2*n +: 2];
         end
      end
   end

   always_comb begin
      reg_rdata = '0;
      if      (reg_addr == ADDR_W'(OFS_CTL0)) reg_rdata = ctl_lo;
      else if (reg_addr == ADDR_W'(OFS_CTL2)) reg_rdata = en_w;
      else if (reg_addr == ADDR_W'(OFS_CTL3)) reg_rdata = ctl_hi;
      else if (reg_addr == ADDR_W'(OFS_STS0)) reg_rdata = sts_lo;
      else if (reg_addr == ADDR_W'(OFS_STS2)) reg_rdata = sts_hi;
   end

   assign irq = |(int_v & en_q);

   logic unused_wdata;
   assign unused_wdata = ^reg_wdata;

   // R4: enables only move on a write to the enable word
   p_en_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_ctl2 |=> $stable(en_q));
   // R10: writes to the spare offsets leave configuration untouched
   p_spare_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && (reg_addr == ADDR_W'(OFS_CTL1) || reg_addr == ADDR_W'(OFS_STS1)))
      |=> ($stable(ch_mode) && $stable(ch_dir) && $stable(en_q) && (ch_start == '0)));
   // R9: no enable, no interrupt
   p_irq_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q == '0) |-> !irq);
endmodule

// File: tb/sim_dmacs_regs.sv
`timescale 1ns/100ps
module sim_dmacs_regs;
   localparam int NCH = 12;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              reg_wr = 1'b0;
   logic [4:0]        reg_addr = '0;
   logic [31:0]       reg_wdata = '0;
   logic [31:0]       reg_rdata;
   logic [NCH-1:0]    ch_done = '0;
   logic [NCH-1:0]    ch_err = '0;
   logic [2*NCH-1:0]  ch_phase = '0;
   logic [2*NCH-1:0]  ch_mode;
   logic [NCH-1:0]    ch_dir;
   logic [NCH-1:0]    ch_start;
   logic              irq;

   dmacs_regs #(.NUM_CH(NCH), .ADDR_W(5)) u0 (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ch_done(ch_done),
      .ch_err(ch_err), .ch_phase(ch_phase), .ch_mode(ch_mode),
      .ch_dir(ch_dir), .ch_start(ch_start), .irq(irq)
   );

   always #5 clk = ~clk;

   int n_tests = 0;
   int n_fail  = 0;
   bit finished = 0;

   logic [1:0] m_mode [NCH];
   bit m_dir [NCH];
   bit m_en [NCH];
   bit m_int [NCH];
   bit m_err [NCH];
   bit m_start [NCH];

   task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_word(input logic [4:0] a);
      logic [31:0] w = '0;
      for (int n = 0; n < NCH; n++) begin
         int k = n % 8;
         bit lo = (n < 8);
         case (a)
            5'h00: if (lo)  w[4*k +: 4] = {1'b0, m_dir[n], m_mode[n]};
            5'h0C: if (!lo) w[4*k +: 4] = {1'b0, m_dir[n], m_mode[n]};
            5'h08: w[lo ? n : n + 8] = m_en[n];
            5'h10, 5'h18: if (lo == (a == 5'h10)) begin
               w[k] = m_int[n];
               w[k+8] = m_err[n];
               w[16+2*k +: 2] = ch_phase[2*n +: 2];
            end
            default: ;
         endcase
      end
      return w;
   endfunction

   task automatic check_all(input string tag);
      logic [4:0] offs [7] = '{5'h00, 5'h04, 5'h08, 5'h0C, 5'h10, 5'h14, 5'h18};
      bit exp_irq = 0;
      for (int n = 0; n < NCH; n++) begin
         chk(tag, $sformatf("mode ch%0d", n), 32'(ch_mode[2*n +: 2]), 32'(m_mode[n]));
         chk(tag, $sformatf("dir ch%0d", n), 32'(ch_dir[n]), 32'(m_dir[n]));
         chk(tag, $sformatf("start ch%0d", n), 32'(ch_start[n]), 32'(m_start[n]));
         exp_irq |= m_int[n] & m_en[n];
      end
      chk(tag, "irq", 32'(irq), 32'(exp_irq));
      for (int i = 0; i < 7; i++) begin
         reg_addr = offs[i];
         #0.5;
         chk(tag, $sformatf("rd %h", offs[i]), reg_rdata, exp_word(offs[i]));
      end
   endtask

   task automatic step(input string tag, input bit wr, input logic [4:0] a, input logic [31:0] d,
                       input logic [NCH-1:0] dn, input logic [NCH-1:0] er, input logic [2*NCH-1:0] ph);
      @(negedge clk);
      reg_wr = wr; reg_addr = a; reg_wdata = d; ch_done = dn; ch_err = er; ch_phase = ph;
      for (int n = 0; n < NCH; n++) begin
         int k = n % 8;
         bit lo = (n < 8);
         m_start[n] = 0;
         if (wr && a == (lo ? 5'h00 : 5'h0C)) begin
            m_mode[n]  = d[4*k +: 2];
            m_dir[n]   = d[4*k+2];
            m_start[n] = (d[4*k +: 2] != 2'd0);
         end
         if (wr && a == 5'h08) m_en[n] = d[lo ? n : n + 8];
         if (dn[n] || er[n]) m_int[n] = 1;
         else if (wr && a == (lo ? 5'h10 : 5'h18) && d[k]) m_int[n] = 0;
         if (er[n]) m_err[n] = 1;
         else if (wr && a == (lo ? 5'h10 : 5'h18) && d[k+8]) m_err[n] = 0;
      end
      @(posedge clk);
      #1;
      reg_wr = 0; ch_done = '0; ch_err = '0;
      check_all(tag);
   endtask

   initial begin
      #(200000 * 10);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog: run did not complete");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      logic [4:0] offs [7] = '{5'h00, 5'h04, 5'h08, 5'h0C, 5'h10, 5'h14, 5'h18};
      void'($urandom(32'd4711));
      for (int n = 0; n < NCH; n++) begin
         m_mode[n] = 0; m_dir[n] = 0; m_en[n] = 0; m_int[n] = 0; m_err[n] = 0; m_start[n] = 0;
      end
      #22;
      check_all("R1 reset");
      @(negedge clk);
      rst_n = 1;

      // R3: ch0 chain, ch1 off, ch2 single with direction set
      step("R3 start", 1, 5'h00, 32'h0000_0601, '0, '0, '0);
      step("R3 pulse end", 0, 5'h00, 32'h0, '0, '0, '0);
      // R2: upper group all ones, reserved bit and absent channels read zero
      step("R2 group2", 1, 5'h0C, 32'hFFFF_FFFF, '0, '0, '0);
      // R4: enable word, only bits 0..7 and 16..19 exist
      step("R4 enables", 1, 5'h08, 32'hFFFF_FFFF, '0, '0, '0);
      // R5: done on channel 9 lands in the second status word, bit 1
      step("R5 done", 0, 5'h00, 32'h0, 12'h200, '0, '0);
      // R6: error on channel 2 sets bits 2 and 10 of the first status word
      step("R6 error", 0, 5'h00, 32'h0, '0, 12'h004, '0);
      // R7: clearing write collides with a new done on channel 2
      step("R7 set-wins", 1, 5'h10, 32'hFFFF_FFFF, 12'h004, '0, '0);
      step("R7 clear", 1, 5'h10, 32'h0000_FFFF, '0, '0, '0);
      step("R9 irq drop", 1, 5'h18, 32'h0000_FFFF, '0, '0, '0);
      // R8: phase fields follow the inputs and ignore writes
      step("R8 phase", 1, 5'h10, 32'hFFFF_0000, '0, '0, 24'hE4_1B6C);
      // R10: spare offsets
      step("R10 ctl1", 1, 5'h04, 32'hFFFF_FFFF, '0, '0, 24'hE4_1B6C);
      step("R10 sts1", 1, 5'h14, 32'hFFFF_FFFF, '0, '0, 24'hE4_1B6C);

      for (int i = 0; i < 400; i++) begin
         logic [NCH-1:0] dn = '0;
         logic [NCH-1:0] er = '0;
         for (int n = 0; n < NCH; n++) begin
            dn[n] = ($urandom % 8) == 0;
            er[n] = ($urandom % 16) == 0;
         end
         step("R2/R3/R4/R5/R6/R7/R8/R9/R10 random", ($urandom % 3) != 0,
              offs[$urandom % 7], $urandom, dn, er, 24'($urandom));
      end

      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule